// File: doc/BRIEF.md
# Voltage-Code Setpoint and Output Window Monitor

This block turns a 5-bit voltage selection code into a regulation setpoint in millivolts. It then judges a digitized output-voltage sample against that setpoint. A window of acceptable voltage around the setpoint drives a power-good flag, and that window has hysteresis. A higher trip level drives an overvoltage flag and a request to hold the low-side switch on. One code is reserved and means "output off". It raises a disable flag, which has the same effect as an external inhibit.

The code space is split by its top bit into two ranges. In each range the lower four bits count downward, so an all-ones field selects the smallest voltage. When the top bit is clear the step is 50 mV. When it is set the step is 100 mV. Every setpoint is a whole multiple of 50 mV. This lets each percentage threshold be computed exactly as a small multiply and a one-bit shift of the setpoint expressed in 50 mV units.

The power-good status comes from a four-window state machine with an extra reset state. The states are `PG_IDLE`, `PG_DISABLED`, `PG_UNDER`, `PG_GOOD` and `PG_OVER`. Its transitions are:
- `T_SHUTDOWN`: any state goes to `PG_DISABLED` while the reserved code is applied.
- `T_DROP_LOW`: `PG_GOOD` goes to `PG_UNDER` when a sample is at or below the lower trip level.
- `T_TRIP_HIGH`: `PG_GOOD` goes to `PG_OVER` when a sample is at or above the upper trip level.
- `T_CLASSIFY`: any state other than `PG_GOOD` moves on a sample by comparing it with the two release levels.

All flag state changes only on a clock edge where the sample strobe is high. The reserved code is the one exception.

Top module: `vid_window_monitor`

## Requirements
- R1: With code bit 4 at 0, `setpoint_mv` equals 1300 + 50·(15 − code[3:0]) and `vid_off` is 0.
- R2: With code bit 4 at 1 and code[3:0] other than 1111, `setpoint_mv` equals 2100 + 100·(14 − code[3:0]) and `vid_off` is 0.
- R3: Code 11111 drives `vid_off` to 1 and `setpoint_mv` to 0 in the same cycle.
- R4: While `vid_off` is 1, `power_good`, `overvolt` and `crowbar_req` are all 0 in that same cycle, and samples taken then set no flag.
- R5: From the good state, a strobed sample at or below ceil(88% of setpoint) clears `power_good` after that clock edge. A sample one millivolt above that level keeps it set.
- R6: From the good state, a strobed sample at or above floor(112% of setpoint) clears `power_good`. A sample one millivolt below keeps it set.
- R7: Once out of the good state, `power_good` returns only on a strobed sample within [ceil(90%), floor(110%)] of the setpoint. Samples one millivolt outside those release levels keep it low.
- R8: `overvolt` is set by a strobed sample at or above floor(117% of setpoint) and cleared by a strobed sample below that level. `crowbar_req` equals `overvolt` in every cycle.
- R9: Flags are registered. They change only on a clock edge where `sample_valid` is 1, except through the reserved code. Without the strobe, the sample value has no effect.
- R10: After synchronous reset, `power_good`, `overvolt` and `crowbar_req` are 0.
- R11: From reset or from the disabled state, the first strobed sample inside the release window sets `power_good`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_code | input | 5 | Voltage selection code |
| sample_mv | input | MV_W (13) | Sensed output voltage in millivolts |
| sample_valid | input | 1 | Strobe that qualifies `sample_mv` |
| setpoint_mv | output | MV_W (13) | Decoded setpoint in millivolts, 0 when off |
| power_good | output | 1 | Output is inside the power-good window |
| overvolt | output | 1 | Overvoltage trip flag |
| crowbar_req | output | 1 | Request to hold the low-side switch on |
| vid_off | output | 1 | Reserved output-off code is applied |

## Verification
The bench sweeps all 32 codes. For every regulating code it places samples exactly on each trip level and each release level, and one millivolt to either side of them. This exposes designs that round a threshold the wrong way, that use a strict comparison where an inclusive one is required, or that treat the hysteresis band as a trip instead of a hold. It also holds the strobe low while the sample swings. A design that reacts to unqualified samples would then drop the overvoltage flag early. Last, it applies the reserved code while the output is good. This catches a design that keeps the power-good flag set until the next sample, or that raises overvoltage against a zero setpoint.

// File: rtl/vwm_pkg.sv
package vwm_pkg;

    // Width of every millivolt quantity (sample, setpoint, thresholds)
    localparam int MV_W   = 13;
    // Setpoints are whole multiples of this step
    localparam int UNIT_MV = 50;
    // Setpoint in UNIT_MV steps, max 70
    localparam int UNIT_W = 7;
    // Width of unit*percent products
    localparam int PROD_W = UNIT_W + 8;

    // Percentages of the setpoint
    localparam int PCT_LO_TRIP = 88;
    localparam int PCT_LO_REL  = 90;
    localparam int PCT_HI_REL  = 110;
    localparam int PCT_HI_TRIP = 112;
    localparam int PCT_OV_TRIP = 117;

    typedef enum logic [2:0] {
        PG_IDLE     = 3'd0,
        PG_DISABLED = 3'd1,
        PG_UNDER    = 3'd2,
        PG_GOOD     = 3'd3,
        PG_OVER     = 3'd4
    } pg_state_t;

    typedef struct packed {
        logic [MV_W-1:0] lo_trip;
        logic [MV_W-1:0] lo_rel;
        logic [MV_W-1:0] hi_rel;
        logic [MV_W-1:0] hi_trip;
        logic [MV_W-1:0] ov_trip;
    } thresh_t;

endpackage

// File: rtl/vwm_vid_decode.sv
module vwm_vid_decode
    import vwm_pkg::*;
(
    input  logic [4:0]        code,
    output logic [UNIT_W-1:0] units,
    output logic [MV_W-1:0]   setpoint_mv,
    output logic              off
);
    // Lower range base: 1300 mV = 26 units; field counts downward from 15
    localparam int LO_BASE_U = 1300 / UNIT_MV;
    // Upper range base: 2100 mV = 42 units; field counts downward from 14
    localparam int HI_BASE_U = 2100 / UNIT_MV;
    localparam int HI_STEP_U = 100 / UNIT_MV;

    logic [UNIT_W-1:0] nib;
    logic [UNIT_W-1:0] units_lo;
    logic [UNIT_W-1:0] units_hi;

    always_comb begin
        nib      = UNIT_W'(code[3:0]);
        units_lo = UNIT_W'(LO_BASE_U) + (UNIT_W'(15) - nib);
        units_hi = UNIT_W'(HI_BASE_U) + UNIT_W'(HI_STEP_U) * (UNIT_W'(14) - nib);
        off      = (code == 5'b11111);
        if (off)
            units = '0;
        else if (code[4])
            units = units_hi;
        else
            units = units_lo;
        setpoint_mv = MV_W'(units) * MV_W'(UNIT_MV);
    end

endmodule

// File: rtl/vwm_thresholds.sv
module vwm_thresholds
    import vwm_pkg::*;
(
    input  logic [UNIT_W-1:0] units,
    output thresh_t           th
);
    // setpoint*pct/100 == units*UNIT_MV*pct/100 == units*pct/2 when UNIT_MV is 50
    localparam int SHIFT = (UNIT_MV == 50) ? 1 : 0;
    localparam int NTH = 5;
    localparam int PCTS [NTH] = '{PCT_LO_TRIP, PCT_LO_REL, PCT_HI_REL, PCT_HI_TRIP, PCT_OV_TRIP};
    // Lower limits round up (narrower window); upper limits round down
    localparam bit ROUND_UP [NTH] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

    logic [MV_W-1:0] lvl [NTH];

    for (genvar i = 0; i < NTH; i++) begin : g_lvl
        logic [PROD_W-1:0] prod;
        always_comb begin
            prod = PROD_W'(units) * PROD_W'(PCTS[i]);
            if (ROUND_UP[i])
                prod = prod + PROD_W'((1 << SHIFT) - 1);
            lvl[i] = MV_W'(prod >> SHIFT);
        end
    end

    always_comb begin
        th.lo_trip = lvl[0];
        th.lo_rel  = lvl[1];
        th.hi_rel  = lvl[2];
        th.hi_trip = lvl[3];
        th.ov_trip = lvl[4];
    end

endmodule

// File: rtl/vwm_window_fsm.sv
module vwm_window_fsm
    import vwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            off,
    input  logic            valid,
    input  logic [MV_W-1:0] sample,
    input  thresh_t         th,
    output logic            good,
    output pg_state_t       state
);
    pg_state_t state_q;
    pg_state_t state_d;
    logic      below_rel;
    logic      above_rel;
    logic      at_lo_trip;
    logic      at_hi_trip;

    always_comb begin
        below_rel  = sample <  th.lo_rel;
        above_rel  = sample >  th.hi_rel;
        at_lo_trip = sample <= th.lo_trip;
        at_hi_trip = sample >= th.hi_trip;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (off) begin
            state_d = PG_DISABLED;                 // T_SHUTDOWN
        end else if (valid) begin
            unique case (state_q)
                PG_GOOD: begin
                    if (at_hi_trip)
                        state_d = PG_OVER;         // T_TRIP_HIGH
                    else if (at_lo_trip)
                        state_d = PG_UNDER;        // T_DROP_LOW
                end
                PG_IDLE, PG_DISABLED, PG_UNDER, PG_OVER: begin
                    if (below_rel)                 // T_CLASSIFY
                        state_d = PG_UNDER;
                    else if (above_rel)
                        state_d = PG_OVER;
                    else
                        state_d = PG_GOOD;
                end
                default: state_d = PG_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PG_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        state = state_q;
        unique case (state_q)
            PG_GOOD:                                      good = 1'b1;
            PG_IDLE, PG_DISABLED, PG_UNDER, PG_OVER:      good = 1'b0;
            default:                                      good = 1'b0;
        endcase
    end

endmodule

// File: rtl/vwm_ov_detect.sv
module vwm_ov_detect
    import vwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            off,
    input  logic            valid,
    input  logic [MV_W-1:0] sample,
    input  logic [MV_W-1:0] trip,
    output logic            ov
);
    logic ov_q;

    always_ff @(posedge clk) begin
        if (rst || off)
            ov_q <= 1'b0;
        else if (valid)
            ov_q <= (sample >= trip);
    end

    assign ov = ov_q;

endmodule

// File: rtl/vid_window_monitor.sv
module vid_window_monitor
    import vwm_pkg::*;
#(
    parameter int SAMPLE_W = MV_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [4:0]          vid_code,
    input  logic [SAMPLE_W-1:0] sample_mv,
    input  logic                sample_valid,
    output logic [SAMPLE_W-1:0] setpoint_mv,
    output logic                power_good,
    output logic                overvolt,
    output logic                crowbar_req,
    output logic                vid_off
);
    logic [UNIT_W-1:0] units;
    logic [MV_W-1:0]   sp_mv;
    logic              off;
    thresh_t           th;
    logic [MV_W-1:0]   sample_n;
    logic              good_raw;
    pg_state_t         pg_state;
    logic              ov_raw;

    assign sample_n = MV_W'(sample_mv);

    vwm_vid_decode u_dec (
        .code        (vid_code),
        .units       (units),
        .setpoint_mv (sp_mv),
        .off         (off)
    );

    vwm_thresholds u_thr (
        .units (units),
        .th    (th)
    );

    vwm_window_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .off    (off),
        .valid  (sample_valid),
        .sample (sample_n),
        .th     (th),
        .good   (good_raw),
        .state  (pg_state)
    );

    vwm_ov_detect u_ov (
        .clk    (clk),
        .rst    (rst),
        .off    (off),
        .valid  (sample_valid),
        .sample (sample_n),
        .trip   (th.ov_trip),
        .ov     (ov_raw)
    );

    // Reserved code masks the flags in the cycle it appears
    always_comb begin
        setpoint_mv = SAMPLE_W'(sp_mv);
        vid_off     = off;
        power_good  = good_raw & ~off;
        overvolt    = ov_raw & ~off;
        crowbar_req = ov_raw & ~off;
    end

endmodule

// File: rtl/vwm_checker.sv
module vwm_checker
    import vwm_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [4:0]      vid_code,
    input logic            sample_valid,
    input logic [MV_W-1:0] setpoint_mv,
    input logic            power_good,
    input logic            overvolt,
    input logic            crowbar_req,
    input logic            vid_off
);
    // R3
    p_reserved_off_r3: assert property (@(posedge clk) disable iff (rst)
        (vid_code == 5'b11111) |-> (vid_off && setpoint_mv == '0));

    // R1 R2
    p_setpoint_range_r2: assert property (@(posedge clk) disable iff (rst)
        !vid_off |-> (setpoint_mv >= MV_W'(1300) && setpoint_mv <= MV_W'(3500)));

    // R4
    p_flags_masked_r4: assert property (@(posedge clk) disable iff (rst)
        vid_off |-> (!power_good && !overvolt && !crowbar_req));

    // R8
    p_crowbar_tracks_r8: assert property (@(posedge clk) disable iff (rst)
        crowbar_req == overvolt);

    // R6 R8: the good window lies below the overvoltage level
    p_good_excludes_ov_r6: assert property (@(posedge clk) disable iff (rst)
        !(power_good && overvolt));

    // R9
    p_pg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !vid_off) |=> (vid_off || $stable(power_good)));

    // R9
    p_ov_rise_needs_sample_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(overvolt) |-> $past(sample_valid));

    // R9
    p_pg_rise_needs_sample_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(power_good) |-> $past(sample_valid));

    // R10
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!power_good && !overvolt));

endmodule

bind vid_window_monitor vwm_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .vid_code     (vid_code),
    .sample_valid (sample_valid),
    .setpoint_mv  (vwm_pkg::MV_W'(setpoint_mv)),
    .power_good   (power_good),
    .overvolt     (overvolt),
    .crowbar_req  (crowbar_req),
    .vid_off      (vid_off)
);

// File: tb/sim_vid_window_monitor.sv
module sim_vid_window_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int W = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [4:0]   vid_code = 5'd0;
    logic [W-1:0] sample_mv = '0;
    logic         sample_valid = 1'b0;
    logic [W-1:0] setpoint_mv;
    logic         power_good;
    logic         overvolt;
    logic         crowbar_req;
    logic         vid_off;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_window_monitor u0 (
        .clk          (clk),
        .rst          (rst),
        .vid_code     (vid_code),
        .sample_mv    (sample_mv),
        .sample_valid (sample_valid),
        .setpoint_mv  (setpoint_mv),
        .power_good   (power_good),
        .overvolt     (overvolt),
        .crowbar_req  (crowbar_req),
        .vid_off      (vid_off)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s code=%b sample=%0d actual=%0d expected=%0d",
                     req, vid_code, sample_mv, act, exp);
        end
    endtask

    // Strobe one sample on the next rising edge; return at the following falling edge
    task automatic put(input int mv);
        sample_mv    = W'(mv);
        sample_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    function automatic int exp_sp(input int c);
        if (c == 31)        return 0;
        else if (c < 16)    return 1300 + 50 * (15 - (c % 16));
        else                return 2100 + 100 * (14 - (c % 16));
    endfunction

    function automatic int pfloor(input int sp, input int pct);
        return (sp * pct) / 100;
    endfunction

    function automatic int pceil(input int sp, input int pct);
        return (sp * pct + 99) / 100;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R10: flags are low out of reset
        chk("R10 pg", int'(power_good), 0);
        chk("R10 ov", int'(overvolt), 0);
        chk("R10 crowbar", int'(crowbar_req), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int c = 0; c < 32; c++) begin
            int sp, lt, lr, hr, ht, ot;
            vid_code = 5'(c);
            #1;
            sp = exp_sp(c);
            if (c == 31) begin
                chk("R3 off", int'(vid_off), 1);
                chk("R3 setpoint", int'(setpoint_mv), 0);
                // R4: a sample under the reserved code sets nothing
                @(negedge clk);
                put(4000);
                chk("R4 ov", int'(overvolt), 0);
                chk("R4 pg", int'(power_good), 0);
                continue;
            end
            chk(c < 16 ? "R1 setpoint" : "R2 setpoint", int'(setpoint_mv), sp);
            chk(c < 16 ? "R1 off" : "R2 off", int'(vid_off), 0);
            lt = pceil(sp, 88);
            lr = pceil(sp, 90);
            hr = pfloor(sp, 110);
            ht = pfloor(sp, 112);
            ot = pfloor(sp, 117);
            @(negedge clk);

            // R11: first sample after disable/reset inside release window
            put(sp);
            chk("R11 pg", int'(power_good), 1);
            chk("R8 ov nominal", int'(overvolt), 0);
            // R5: lower trip level
            put(lt + 1);
            chk("R5 pg above trip", int'(power_good), 1);
            put(lt);
            chk("R5 pg at trip", int'(power_good), 0);
            // R7: lower release level
            put(lr - 1);
            chk("R7 pg below release", int'(power_good), 0);
            put(lr);
            chk("R7 pg at release", int'(power_good), 1);
            // R6: upper trip level
            put(ht - 1);
            chk("R6 pg below trip", int'(power_good), 1);
            put(ht);
            chk("R6 pg at trip", int'(power_good), 0);
            // R7: upper release level
            put(hr + 1);
            chk("R7 pg above release", int'(power_good), 0);
            put(hr);
            chk("R7 pg at upper release", int'(power_good), 1);
            // R8: overvoltage level
            put(ot - 1);
            chk("R8 ov below trip", int'(overvolt), 0);
            put(ot);
            chk("R8 ov at trip", int'(overvolt), 1);
            chk("R8 crowbar", int'(crowbar_req), 1);
            // R9: unstrobed samples do nothing
            sample_mv = W'(sp);
            repeat (3) @(negedge clk);
            chk("R9 ov held", int'(overvolt), 1);
            chk("R9 pg held", int'(power_good), 0);
            put(sp);
            chk("R8 ov cleared", int'(overvolt), 0);
            chk("R8 crowbar cleared", int'(crowbar_req), 0);
            chk("R7 pg back", int'(power_good), 1);
            // R4: reserved code forces pg low at once
            vid_code = 5'b11111;
            #1;
            chk("R4 pg masked", int'(power_good), 0);
            @(negedge clk);
            put(4000);
            chk("R4 ov masked", int'(overvolt), 0);
            chk("R4 crowbar masked", int'(crowbar_req), 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule